// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects seven reset requests, sorts each into an immediate class or a bus-synchronised class, and drives four registered reset lines. One line goes to the external reset pin, one to the clock unit, one to the master reset of the remaining logic, and one tells internal logic that the processor ran its reset instruction. A request in the immediate class takes effect on the next clock edge. A request in the bus-synchronised class is held pending until the bus cycle in flight ends.

While a request is pending, the block forces the bus monitor on. If the cycle stalls, the monitor ends it by timeout. Once asserted, the reset lines stay active for a minimum window after the last request drops. A one-hot cause register keeps the source that started the most recent reset.

Top module: `reset_hub`

## Requirements
- R1: Request bits are `src_req[0]` power-up, `[1]` loss of clock, `[2]` halt, `[3]` watchdog, `[4]` external pin, `[5]` test mode, `[6]` reset instruction. A lower index has higher priority. Bits 0, 2, 3 and 6 are immediate. Bits 1, 4 and 5 are bus-synchronised.
- R2: An immediate request that is high at a clock edge asserts its reset lines at that edge, from any state.
- R3: When the block is idle, a bus-synchronised request moves it to pending. The lines rise on the first later edge at which `bus_busy` is low, `bus_done` is high or `bus_term` is high.
- R4: `bmon_en` is high exactly while a bus-synchronised reset is pending, and no reset line is active in that time.
- R5: If the cycle does not end, `bus_term` pulses for one clock BMON_TIMEOUT (64) cycles after `bmon_en` rose. The pending reset asserts on the next edge.
- R6: Line masks are set by source. Power-up, loss of clock, halt, watchdog and external each assert external, clock-unit and master. Test mode asserts external and master. The reset instruction asserts external and system.
- R7: An immediate request arriving while a request is pending asserts at once. It takes the cause, and the pending source's lines are added.
- R8: The lines release together on the HOLD_CYCLES-th (16) consecutive edge that samples all requests low.
- R9: `cause` is one-hot. At the edge where reset asserts it loads the highest-priority immediate request if there is one; otherwise it loads the pending source. It then holds until the next reset starts.
- R10: After `rst` all outputs are zero.
- R11: While reset is active, any request ORs its own line mask into the active lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system output clock |
| rst | input | 1 | synchronous active-high block reset |
| src_req | input | 7 | reset requests, bit map in R1 |
| bus_busy | input | 1 | a bus cycle is in flight |
| bus_done | input | 1 | the bus cycle terminates normally this clock |
| rst_ext_o | output | 1 | external pin reset |
| rst_clk_o | output | 1 | clock-unit reset |
| rst_mst_o | output | 1 | master reset |
| rst_sys_o | output | 1 | reset-instruction indication |
| bmon_en_o | output | 1 | bus monitor forced on |
| bus_term_o | output | 1 | bus monitor termination pulse |
| cause_o | output | 7 | one-hot cause of the last reset |

## Verification
The bus-monitor timeout and an immediate-request upgrade can fall in the same cycle. When they do, both try to end the pending state at one edge. The bench holds the bus busy until `bus_term` is high, then raises the halt request in that same cycle. It judges the result by whether the cause shows halt rather than the pending external source, and by whether the lines carry both masks. Random phases with long busy stretches also produce this collision, and a cycle model written from the requirements checks it every cycle.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int NSRC  = 7;
  localparam int NLINE = 4;
  // line bits: [0] external, [1] clock unit, [2] master, [3] system
  localparam logic [NSRC-1:0] ASYNC_SET = 7'b1001101;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_ACT} rh_state_e;

  function automatic logic [NLINE-1:0] src_lines(input int idx);
    case (idx)
      5:       return 4'b0101;
      6:       return 4'b1001;
      default: return 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/rh_prio.sv
module rh_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] hot,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i]    = vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/rh_linemap.sv
module rh_linemap
  import rh_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  output logic [NLINE-1:0] lines
);
  logic [NLINE-1:0] part [NSRC+1];
  assign part[0] = '0;
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign part[i+1] = part[i] | (req[i] ? src_lines(i) : '0);
  end
  assign lines = part[NSRC];
endmodule

// File: rtl/rh_bmon.sv
module rh_bmon #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic term
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      term <= 1'b0;
    end else begin
      term <= (cnt == LIMIT - 1'b1);
      if (cnt < LIMIT) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rh_hold.sv
module rh_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic any_req,
  output logic expire
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);
  logic [HW-1:0] cnt;

  assign expire = active && !any_req && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || any_req || expire) cnt <= '0;
    else                                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import rh_pkg::*;
#(
  parameter int HOLD_CYCLES  = 16,
  parameter int BMON_TIMEOUT = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic            bus_busy,
  input  logic            bus_done,
  output logic            rst_ext_o,
  output logic            rst_clk_o,
  output logic            rst_mst_o,
  output logic            rst_sys_o,
  output logic            bmon_en_o,
  output logic            bus_term_o,
  output logic [NSRC-1:0] cause_o
);
  rh_state_e        st_q, st_n;
  logic [NLINE-1:0] lines_q, lines_n;
  logic [NSRC-1:0]  cause_q, cause_n;
  logic [NSRC-1:0]  pend_q, pend_n;
  logic             bmon_q;

  logic [NSRC-1:0]  a_hot, s_hot;
  logic             a_any, s_any;
  logic [NLINE-1:0] req_lines, pend_lines;
  logic             expire, term, bus_free;

  rh_prio #(.N(NSRC)) u_apri (.vec(src_req & ASYNC_SET),  .hot(a_hot), .any(a_any));
  rh_prio #(.N(NSRC)) u_spri (.vec(src_req & ~ASYNC_SET), .hot(s_hot), .any(s_any));
  rh_linemap u_reqmap  (.req(src_req), .lines(req_lines));
  rh_linemap u_pendmap (.req(pend_q),  .lines(pend_lines));

  rh_bmon #(.TIMEOUT(BMON_TIMEOUT)) u_bmon (
    .clk(clk), .rst(rst), .run(bmon_q), .term(term));

  rh_hold #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .active(st_q == ST_ACT),
    .any_req(|src_req), .expire(expire));

  assign bus_free = !bus_busy || bus_done || term;

  always_comb begin
    st_n    = st_q;
    lines_n = lines_q;
    cause_n = cause_q;
    pend_n  = pend_q;
    case (st_q)
      ST_IDLE: begin
        if (a_any) begin
          st_n    = ST_ACT;
          lines_n = req_lines;
          cause_n = a_hot;
        end else if (s_any) begin
          st_n   = ST_PEND;
          pend_n = s_hot;
        end
      end
      ST_PEND: begin
        if (a_any) begin
          st_n    = ST_ACT;
          lines_n = req_lines | pend_lines;
          cause_n = a_hot;
          pend_n  = '0;
        end else if (bus_free) begin
          st_n    = ST_ACT;
          lines_n = req_lines | pend_lines;
          cause_n = pend_q;
          pend_n  = '0;
        end
      end
      ST_ACT: begin
        lines_n = lines_q | req_lines;
        if (expire) begin
          st_n    = ST_IDLE;
          lines_n = '0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      lines_q <= '0;
      cause_q <= '0;
      pend_q  <= '0;
      bmon_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      lines_q <= lines_n;
      cause_q <= cause_n;
      pend_q  <= pend_n;
      bmon_q  <= (st_n == ST_PEND);
    end
  end

  assign rst_ext_o  = lines_q[0];
  assign rst_clk_o  = lines_q[1];
  assign rst_mst_o  = lines_q[2];
  assign rst_sys_o  = lines_q[3];
  assign bmon_en_o  = bmon_q;
  assign bus_term_o = term;
  assign cause_o    = cause_q;
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk
  import rh_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_req,
  input logic            bus_busy,
  input logic            bus_done,
  input logic            rst_ext_o,
  input logic            rst_clk_o,
  input logic            rst_mst_o,
  input logic            rst_sys_o,
  input logic            bmon_en_o,
  input logic            bus_term_o,
  input logic [NSRC-1:0] cause_o
);
  // R2
  async_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (|(src_req & ASYNC_SET)) |=> rst_ext_o);
  // R6
  clk_needs_mst_chk: assert property (@(posedge clk) disable iff (rst)
    rst_clk_o |-> rst_mst_o);
  // R6
  ext_with_any_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_clk_o || rst_mst_o || rst_sys_o) |-> rst_ext_o);
  // R4
  pend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bmon_en_o |-> !rst_ext_o);
  // R4
  pend_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bmon_en_o) |-> rst_ext_o);
  // R3
  sync_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (bmon_en_o && bus_busy && !bus_done && !bus_term_o && !(|(src_req & ASYNC_SET)))
      |=> (bmon_en_o && !rst_ext_o));
  // R5
  term_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_term_o |=> !bus_term_o);
  // R5
  term_then_reset_chk: assert property (@(posedge clk) disable iff (rst)
    bus_term_o |=> rst_ext_o);
  // R9
  cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_o));
  // R8
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_ext_o) |-> ($past(src_req) == '0));
endmodule

bind reset_hub reset_hub_chk u_chk (.*);

// File: tb/reset_hub_tb_top.sv
module reset_hub_tb_top;
  localparam int HOLD = 16;
  localparam int TO   = 64;
  localparam logic [6:0] ASY = 7'b1001101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] src_req = '0;
  logic       bus_busy = 1'b0, bus_done = 1'b0;
  logic       rst_ext_o, rst_clk_o, rst_mst_o, rst_sys_o, bmon_en_o, bus_term_o;
  logic [6:0] cause_o;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  reset_hub #(.HOLD_CYCLES(HOLD), .BMON_TIMEOUT(TO)) dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_busy(bus_busy), .bus_done(bus_done),
    .rst_ext_o(rst_ext_o), .rst_clk_o(rst_clk_o), .rst_mst_o(rst_mst_o),
    .rst_sys_o(rst_sys_o), .bmon_en_o(bmon_en_o), .bus_term_o(bus_term_o),
    .cause_o(cause_o));

  // reference model state
  int         m_st = 0;  // 0 idle, 1 pending, 2 active
  logic [3:0] m_lines = '0;
  logic [6:0] m_cause = '0, m_pend = '0;
  logic       m_bmon = 0, m_term = 0;
  int         m_wait = 0, m_hold = 0;

  function automatic logic [6:0] first_bit(input logic [6:0] v);
    for (int i = 0; i < 7; i++) if (v[i]) return 7'(1) << i;
    return '0;
  endfunction

  function automatic logic [3:0] mask_of(input logic [6:0] v);
    logic [3:0] m = '0;
    for (int i = 0; i < 7; i++)
      if (v[i]) m |= (i == 5) ? 4'b0101 : (i == 6) ? 4'b1001 : 4'b0111;
    return m;
  endfunction

  task automatic model_edge(input logic [6:0] r, input logic busy, input logic dn);
    logic [6:0] a = r & ASY;
    logic old_bmon = m_bmon;
    logic old_term = m_term;
    int old_wait = m_wait;
    case (m_st)
      0: if (a != 0) begin
           m_st = 2; m_lines = mask_of(r); m_cause = first_bit(a); m_hold = 0;
         end else if (r != 0) begin
           m_st = 1; m_pend = first_bit(r & ~ASY);
         end
      1: if (a != 0) begin
           m_st = 2; m_lines = mask_of(r) | mask_of(m_pend); m_cause = first_bit(a); m_hold = 0;
         end else if (!busy || dn || old_term) begin
           m_st = 2; m_lines = mask_of(r) | mask_of(m_pend); m_cause = m_pend; m_hold = 0;
         end
      default: begin
        m_lines |= mask_of(r);
        if (r != 0) m_hold = 0;
        else if (m_hold == HOLD - 1) begin m_st = 0; m_lines = '0; m_hold = 0; end
        else m_hold++;
      end
    endcase
    m_term = old_bmon && (old_wait == TO - 1);
    m_wait = !old_bmon ? 0 : (old_wait < TO ? old_wait + 1 : old_wait);
    m_bmon = (m_st == 1);
  endtask

  task automatic chk(input string tag, input string what, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "lines(R6)", {3'b0, rst_sys_o, rst_mst_o, rst_clk_o, rst_ext_o}, {3'b0, m_lines});
    chk(tag, "cause(R9)", cause_o, m_cause);
    chk(tag, "bmon(R4)", {6'b0, bmon_en_o}, {6'b0, m_bmon});
    chk(tag, "term(R5)", {6'b0, bus_term_o}, {6'b0, m_term});
  endtask

  // called at a negedge; drives inputs, crosses one edge, checks at next negedge
  task automatic cyc(input logic [6:0] r, input logic busy, input logic dn, input string tag);
    src_req = r; bus_busy = busy; bus_done = dn;
    @(posedge clk);
    model_edge(r, busy, dn);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic settle(input string tag);
    for (int i = 0; i < HOLD + 4; i++) cyc('0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R10");
    // each source alone, bus idle
    for (int s = 0; s < 7; s++) begin
      cyc(7'(1) << s, 1'b0, 1'b0, "R2");
      cyc('0, 1'b0, 1'b0, "R6");
      settle("R8");
    end
    // simultaneous halt and watchdog -> halt wins
    cyc(7'b0001100, 1'b0, 1'b0, "R1");
    settle("R8");
    // loss of clock with halt: immediate class acts, cause halt
    cyc(7'b0000110, 1'b0, 1'b0, "R1");
    settle("R8");
    // external pending on busy bus, ended by bus_done
    cyc(7'b0010000, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 5; i++) cyc('0, 1'b1, 1'b0, "R3");
    cyc('0, 1'b1, 1'b1, "R3");
    cyc('0, 1'b0, 1'b0, "R9");
    settle("R8");
    // test mode pending, ended by timeout
    cyc(7'b0100000, 1'b1, 1'b0, "R4");
    for (int i = 0; i < TO + 2; i++) cyc('0, 1'b1, 1'b0, "R5");
    settle("R8");
    // upgrade while pending
    cyc(7'b0010000, 1'b1, 1'b0, "R7");
    cyc('0, 1'b1, 1'b0, "R7");
    cyc(7'b1000000, 1'b1, 1'b0, "R7");
    cyc('0, 1'b1, 1'b0, "R7");
    settle("R8");
    // timeout and halt in the same cycle
    cyc(7'b0010000, 1'b1, 1'b0, "R5");
    while (!bus_term_o) cyc('0, 1'b1, 1'b0, "R5");
    cyc(7'b0000100, 1'b1, 1'b0, "R7");
    settle("R8");
    // request added while active, held request delays release
    cyc(7'b1000000, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 5; i++) cyc(7'b0100000, 1'b0, 1'b0, "R11");
    cyc(7'b0000001, 1'b0, 1'b0, "R11");
    settle("R8");
    // random phases
    for (int i = 0; i < 6000; i++) begin
      logic [6:0] r = '0;
      logic stuck = ((i / 500) % 2) == 1;
      for (int b = 0; b < 7; b++) if ($urandom % 60 == 0) r[b] = 1'b1;
      cyc(r, stuck ? 1'b1 : ($urandom % 4 != 0), stuck ? 1'b0 : ($urandom % 10 == 0), "R3");
    end
    done_flag = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule